// File: doc/BRIEF.md
# Single-Channel Timer-Counter with Compare Trigger

This block is one timer-counter channel with a small word-addressed register port. It counts ticks of a prescaled version of the system clock. The prescale ratio comes from a clock-select field in the mode register. A limit register holds a compare value. When the running count equals that value on a counting tick, the block records a compare event. If auto-restart is enabled in the mode register, the same event also returns the counter to zero.

Software controls the counter clock through a command register. This register holds three single-bit actions: start, stop and restart. A restart clears the counter, clears the prescaler phase and starts counting. A stop in the same write always overrides a start. The compare event sets a status flag that clears when the status register is read. Interrupt enable and disable registers set and clear a mask, and the interrupt output is the flag qualified by that mask. A group-control register exists for software compatibility and accepts any write without effect.

Top module: `tc_channel`

Register offsets (word addresses):
- 0: command, write-only. Bit 0 starts the clock, bit 1 stops it, bit 2 restarts.
- 1: mode, read/write. Bits 2:0 are the clock select, bit 14 is auto-restart.
- 2: count, read-only.
- 3: limit, read/write, 16 bits.
- 4: status, read-only. Bit 0 is the compare flag.
- 5: interrupt enable, write-one-to-set.
- 6: interrupt disable, write-one-to-clear.
- 7: interrupt mask, read-only.
- 8: group control, write has no effect.

## Requirements
- R1: After reset, count, mode, limit, status and mask read 0 and irq is low.
- R2: A command write with bit 2 set (and bit 1 clear) clears the counter and the prescaler phase and starts counting. After the n-th rising edge that follows the write edge, count reads floor(n/D), where D is the selected divisor.
- R3: A command write with bits 0 and 1 both set stops the counter clock.
- R4: A command write of 2 stops counting. The count holds its value and is not cleared.
- R5: A command write with only bit 0 set resumes counting from the held value, without clearing it.
- R6: Clock-select codes 0 to 4 divide the system clock by 2, 8, 32, 128 and 1024. Codes 5 to 7 never advance the count.
- R7: With mode bit 14 set and limit L, the count cycles through 0..L and returns to 0 on the tick after it reads L.
- R8: With mode bit 14 clear, the count moves past the limit. The compare flag (status bit 0) is still set when the count equals the limit on a tick.
- R9: irq is high exactly while the compare flag and the mask bit 0 are both set.
- R10: Writing a 1 in bit 0 of the interrupt enable register sets the mask bit, and writing a 1 in bit 0 of the disable register clears it. Writing 0 to either register has no effect. Writing all ones to the disable register masks every source.
- R11: A read of the status register clears the compare flag after that read.
- R12: Any write to the group-control register leaves the count, mode and counting unchanged.
- R13: A command write with bits 1 and 2 both set clears the counter but leaves it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; qualifies read side effects |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Masked compare interrupt |

## Verification
The bench starts each clock-select code with a restart and then checks the count on every cycle. This catches an off-by-one divisor, a prescaler that is not realigned by the restart, and a code from 5 to 7 that still counts. In auto-restart mode, each cycle is compared against the closed-form sequence. A design that wrapped one tick early or late would drift out of step within the first period, and would raise the flag on the wrong edge. The bench also covers the command write collisions: start with stop, restart with stop, and a bare stop. A design that let the start bit win would keep counting, and a design that treated a stop as a restart would show a zero count. Finally, the bench covers a flag set during a masked interval and the clearing of the flag by a read. A wrong design would show irq high with the mask clear, or a flag that stays set after the read.

// File: rtl/tc_channel.sv
module tc_channel #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PRE_W    = 10;
  localparam int TRIG_BIT = 14;
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_IDIS  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(7);

  logic [CNT_W-1:0] cnt, limit;
  logic [PRE_W-1:0] pre;
  logic [2:0]       clksel;
  logic             trig_en, run, flag, mask, tick, hit;

  wire wr_cmd   = wr_en && addr == A_CMD;
  wire restart  = wr_cmd && wdata[2];
  wire advance  = run && tick && !restart;
  wire rd_stat  = rd_en && addr == A_STAT;

  always_comb begin
    case (clksel)
      3'd0:    tick = pre[0];
      3'd1:    tick = &pre[2:0];
      3'd2:    tick = &pre[4:0];
      3'd3:    tick = &pre[6:0];
      3'd4:    tick = &pre[9:0];
      default: tick = 1'b0;
    endcase
  end

  assign hit = cnt == limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre <= '0;
    else if (restart) pre <= '0;
    else              pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (advance) cnt <= (hit && trig_en) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            run <= 1'b0;
    else if (wr_cmd && wdata[1])           run <= 1'b0;
    else if (wr_cmd && (wdata[0] | wdata[2])) run <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clksel  <= '0;
      trig_en <= 1'b0;
      limit   <= '0;
    end else if (wr_en) begin
      if (addr == A_MODE) begin
        clksel  <= wdata[2:0];
        trig_en <= wdata[TRIG_BIT];
      end
      if (addr == A_LIMIT) limit <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (advance && hit)    flag <= 1'b1;
    else if (rd_stat)           flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     mask <= 1'b0;
    else if (wr_en && addr == A_IDIS && wdata[0])   mask <= 1'b0;
    else if (wr_en && addr == A_IEN && wdata[0])    mask <= 1'b1;
  end

  assign irq = flag & mask;

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE:  begin rdata[2:0] = clksel; rdata[TRIG_BIT] = trig_en; end
      A_COUNT: rdata[CNT_W-1:0] = cnt;
      A_LIMIT: rdata[CNT_W-1:0] = limit;
      A_STAT:  rdata[0] = flag;
      A_IMASK: rdata[0] = mask;
      default: rdata = '0;
    endcase
  end

  p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[1]) |=> !run);

  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt));

  p_dead_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clksel > 3'd4 && !restart) |=> $stable(cnt));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && hit && trig_en) |=> cnt == '0);

  p_match_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && hit) |=> flag);

  p_mask_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IDIS && &wdata) |=> !irq);

  p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
endmodule

// File: tb/tc_channel_bench.sv
module tc_channel_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  int compared = 0, mismatched = 0;
  bit done = 0;

  localparam logic [3:0] CMD = 0, MODE = 1, COUNT = 2, LIMIT = 3,
                         STAT = 4, IEN = 5, IDIS = 6, IMASK = 7, GROUP = 8;

  tc_channel u_tc_channel (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_clear(output logic [31:0] d);
    @(negedge clk); addr = STAT; rd_en = 1; #1; d = rdata;
    @(posedge clk); #1; rd_en = 0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int shift_of(input int c);
    case (c) 0: return 1; 1: return 3; 2: return 5; 3: return 7; default: return 10; endcase
  endfunction

  initial begin
    logic [31:0] v;
    #12 rst_n = 1; #1;
    // R1 reset values
    peek(COUNT, v); chk("R1 count", v, 0);
    peek(MODE, v);  chk("R1 mode", v, 0);
    peek(LIMIT, v); chk("R1 limit", v, 0);
    peek(STAT, v);  chk("R1 status", v, 0);
    peek(IMASK, v); chk("R1 mask", v, 0);
    chk("R1 irq", irq, 0);

    // R6 sweep of every clock-select code, also exercising R2
    for (int c = 0; c < 8; c++) begin
      int lim;
      wr(CMD, 2); wr(MODE, c); wr(LIMIT, 32'hFFFF); wr(CMD, 4);
      lim = (c == 4) ? 2100 : (c > 4) ? 50 : 300;
      for (int n = 1; n <= lim; n++) begin
        wait_edges(1); #0;
        peek(COUNT, v);
        chk(c == 0 ? "R2" : "R6", v, c < 5 ? (n >> shift_of(c)) : 0);
      end
    end

    // R4, R5, R3, R13 command behaviour (divide by 2, ticks on even edges after restart)
    wr(CMD, 2); wr(MODE, 0); wr(CMD, 4);
    wait_edges(10); peek(COUNT, v); chk("R2", v, 5);
    wr(CMD, 2);
    wait_edges(20); peek(COUNT, v); chk("R4", v, 5);
    wr(CMD, 1);
    wait_edges(10); peek(COUNT, v); chk("R5", v, 10);
    wr(CMD, 3);
    wait_edges(10); peek(COUNT, v); chk("R3", v, 10);
    wr(CMD, 6);
    peek(COUNT, v); chk("R13 cleared", v, 0);
    wait_edges(10); peek(COUNT, v); chk("R13 stopped", v, 0);

    // R12 group-control write has no effect
    wr(CMD, 4); wr(GROUP, 32'hFFFF_FFFF);
    wait_edges(19); peek(COUNT, v); chk("R12 count", v, 10);
    wr(GROUP, 0);
    peek(MODE, v); chk("R12 mode", v, 0);
    wait_edges(9); peek(COUNT, v); chk("R12 count", v, 15);

    // R8 no auto-restart: count passes limit, flag set
    wr(CMD, 2); rd_clear(v); wr(LIMIT, 3); wr(CMD, 4);
    wait_edges(7); peek(STAT, v); chk("R8 flag early", v, 0);
    wait_edges(1); peek(STAT, v); chk("R8 flag", v, 1);
    wait_edges(12); peek(COUNT, v); chk("R8 past limit", v, 10);
    chk("R9 irq masked", irq, 0);

    // R10 mask handling
    wr(IEN, 0); peek(IMASK, v); chk("R10 ien zero", v, 0);
    wr(IEN, 1); peek(IMASK, v); chk("R10 ien", v, 1);
    chk("R9 irq", irq, 1);
    wr(IDIS, 0); peek(IMASK, v); chk("R10 idis zero", v, 1);
    wr(IDIS, 32'hFFFF_FFFF); peek(IMASK, v); chk("R10 idis all", v, 0);
    chk("R9 irq off", irq, 0);
    wr(IEN, 1);

    // R11 read clears the flag
    rd_clear(v); chk("R11 read value", v, 1);
    peek(STAT, v); chk("R11 cleared", v, 0);
    chk("R9 irq after clear", irq, 0);

    // R7 auto-restart, limit 5, divide by 2
    wr(CMD, 2); wr(MODE, 32'h4000); wr(LIMIT, 5);
    peek(MODE, v); chk("R7 mode readback", v, 32'h4000);
    wr(CMD, 4);
    for (int n = 1; n <= 60; n++) begin
      wait_edges(1); #0;
      peek(COUNT, v); chk("R7", v, (n / 2) % 6);
      if (n == 11) chk("R9 irq before match", irq, 0);
      if (n == 12) chk("R9 irq at match", irq, 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog got=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule